// File: doc/BRIEF.md
# Memory Subsystem Event Counter Bank

This block is a bank of performance counters that sits beside a memory controller and is reached through a plain 32-bit register port. The port takes a byte address, a write strobe and write data, and returns read data in the same cycle. Sixteen general 32-bit counters each watch one of 64 event inputs. Each counter chooses its input through a byte-wide selector, and four selectors share one register. A 56-bit cycle counter runs next to them. One control register starts, stops and clears the whole bank.

Software cannot write a counter directly. To load a start value, it first writes a code into a test-select register; the code is 19 plus the counter number. It then writes the value into a shared preload register, and finally writes zero back into test-select. When a general counter wraps past its maximum, it raises a one-cycle pulse on its own output line. A separate interrupt block collects these pulses.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every general counter, the cycle counter, every selector byte and the test-select code are zero. The run flag is clear, and no overflow pulse is raised.
- R2: A write to 0xC00 controls the bank. Bit 2 clears all counters and the run flag. Bit 1 clears the run flag. Bit 0 sets the run flag. When several bits are written together, bit 2 wins over bit 1, and bit 1 wins over bit 0. Reading 0xC00 returns the run flag in bit 0 and zero in every other bit. Selector bytes keep their values when the bank is cleared.
- R3: The selector for counter n is the byte at bit 8·(n mod 4) of the register at 0xC68 + 4·(n/4). In that byte, bit 7 is the enable and bits 5:0 are the event number. Bit 6 is not stored and always reads back as 0.
- R4: General counter n is read at 0xC78 + 4·n. It increases by one on every clock edge at which the run flag is set, its enable is set and its chosen event input is high. The run flag counts as set from the edge after the start write up to and including the edge of the stop write.
- R5: The 56-bit cycle counter increases on every clock edge at which the run flag is set. 0xC14 returns its low 32 bits. 0xC10 returns its upper 24 bits in bits 23:0, with bits 31:24 reading as 0.
- R6: The test-select register at 0xC08 holds the low 8 bits of the write data and reads them back. A write to 0xC0C with a code of 19+n in test-select loads the written value into counter n. On that edge the load wins over counting. Reads of 0xC0C return 0.
- R7: A write to 0xC0C while test-select holds a code outside 19..34 changes no counter. This includes code 0.
- R8: A general counter wraps from 0xFFFFFFFF to 0. Its output ovf_pulse[n] is high for exactly the one cycle that follows the wrapping edge.
- R9: Reads of any offset not named above, including misaligned offsets, return 0. Writes to such offsets, and writes to the counter offsets, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| events_in | input | 64 | Event inputs from the memory controller |
| ovf_pulse | output | 16 | One-cycle wrap pulse per general counter |

## Verification
Register writes act on the edge that samples the write strobe. Counters therefore count the edges strictly after the start-write edge, up to and including the stop-write edge. The bench times each run in whole cycles between these two writes, so a run of N cycles gives counts of exactly N. Read data is combinational, so each expected value is queued at the moment the address is driven. A monitor then compares it a quarter period later, with counting stopped, so the value cannot move. Overflow pulses are registered and are checked at the falling edge after the wrap edge and at the falling edges either side of it. A preload issued during a run is checked through the exact count that follows it.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

   localparam logic [11:0] OFS_CTRL     = 12'hC00;
   localparam logic [11:0] OFS_TSEL     = 12'hC08;
   localparam logic [11:0] OFS_PRELOAD  = 12'hC0C;
   localparam logic [11:0] OFS_CYC_HI   = 12'hC10;
   localparam logic [11:0] OFS_CYC_LO   = 12'hC14;
   localparam logic [11:0] OFS_SEL_BASE = 12'hC68;
   localparam logic [11:0] OFS_CNT_BASE = 12'hC78;

   localparam int CTRL_GO_BIT   = 0;
   localparam int CTRL_HALT_BIT = 1;
   localparam int CTRL_WIPE_BIT = 2;

   localparam int SEL_EN_BIT  = 7;
   localparam int SEL_ID_W    = 6;
   localparam int LOAD_CODE_0 = 19;

   typedef struct packed {
      logic                en;
      logic [SEL_ID_W-1:0] id;
   } evsel_t;

   function automatic logic [7:0] sel_to_byte(evsel_t s);
      return {s.en, 1'b0, s.id};
   endfunction

endpackage

// File: rtl/pcb_ctrl.sv
module pcb_ctrl
   import pcb_pkg::*;
#(
   parameter int NUM_CTR = 16,
   parameter int ADDR_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [31:0]       wdata_i,
   output logic              run_o,
   output logic              clr_o,
   output evsel_t            sel_o [NUM_CTR],
   output logic [7:0]        tsel_o,
   output logic [NUM_CTR-1:0] load_o
);

   logic wr_ctrl, wr_tsel, wr_pre;

   assign wr_ctrl = we_i && (addr_i == ADDR_W'(OFS_CTRL));
   assign wr_tsel = we_i && (addr_i == ADDR_W'(OFS_TSEL));
   assign wr_pre  = we_i && (addr_i == ADDR_W'(OFS_PRELOAD));
   assign clr_o   = wr_ctrl && wdata_i[CTRL_WIPE_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_o <= 1'b0;
      end else if (wr_ctrl) begin
         if (wdata_i[CTRL_WIPE_BIT] || wdata_i[CTRL_HALT_BIT])
            run_o <= 1'b0;
         else if (wdata_i[CTRL_GO_BIT])
            run_o <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         tsel_o <= '0;
      else if (wr_tsel)
         tsel_o <= wdata_i[7:0];
   end

   for (genvar g = 0; g < NUM_CTR; g++) begin : g_sel
      localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(OFS_SEL_BASE + 4 * (g / 4));
      localparam int                LANE     = 8 * (g % 4);
      always_ff @(posedge clk) begin
         if (!rst_n)
            sel_o[g] <= '0;
         else if (we_i && (addr_i == SEL_ADDR))
            sel_o[g] <= '{en: wdata_i[LANE + SEL_EN_BIT], id: wdata_i[LANE +: SEL_ID_W]};
      end
      assign load_o[g] = wr_pre && (tsel_o == 8'(LOAD_CODE_0 + g));
   end

   AST_WIPE_BEATS_GO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata_i[CTRL_WIPE_BIT]) |=> !run_o); // R2
   AST_GO_ALONE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata_i[2:0] == 3'b001) |=> run_o); // R2
   AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_o)); // R6

endmodule

// File: rtl/pcb_counter.sv
module pcb_counter
   import pcb_pkg::*;
#(
   parameter int CTR_W   = 32,
   parameter int NUM_EVT = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic               clr_i,
   input  evsel_t             sel_i,
   input  logic [NUM_EVT-1:0] events_i,
   input  logic               load_i,
   input  logic [CTR_W-1:0]   load_val_i,
   output logic [CTR_W-1:0]   cnt_o,
   output logic               ovf_o
);

   logic hit, inc;

   if (NUM_EVT == 64) begin : g_full
      assign hit = events_i[sel_i.id];
   end else begin : g_pad
      logic [63:0] ev_pad;
      assign ev_pad = 64'(events_i);
      assign hit    = ev_pad[sel_i.id];
   end

   assign inc = run_i && sel_i.en && hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_o <= '0;
         ovf_o <= 1'b0;
      end else begin
         ovf_o <= 1'b0;
         if (clr_i) begin
            cnt_o <= '0;
         end else if (load_i) begin
            cnt_o <= load_val_i;
         end else if (inc) begin
            cnt_o <= cnt_o + 1'b1;
            ovf_o <= &cnt_o;
         end
      end
   end

   AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (cnt_o == '0)); // R8
   AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> !ovf_o); // R8
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !load_i && !clr_i) |=> $stable(cnt_o)); // R4
   AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_o == '0)); // R2
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !clr_i) |=> (cnt_o == $past(load_val_i))); // R6

endmodule

// File: rtl/pcb_cycle.sv
module pcb_cycle #(
   parameter int CYC_W = 56
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             clr_i,
   output logic [CYC_W-1:0] cyc_o
);

   if (CYC_W > 32) begin : g_split
      localparam int HI_W = CYC_W - 32;
      logic [31:0]   lo_q;
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr_i) begin
            lo_q <= '0;
            hi_q <= '0;
         end else if (run_i) begin
            lo_q <= lo_q + 32'd1;
            if (&lo_q)
               hi_q <= hi_q + 1'b1;
         end
      end
      assign cyc_o = {hi_q, lo_q};
   end else begin : g_flat
      logic [CYC_W-1:0] c_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr_i)
            c_q <= '0;
         else if (run_i)
            c_q <= c_q + 1'b1;
      end
      assign cyc_o = c_q;
   end

   AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !clr_i) |=> (cyc_o == $past(cyc_o) + 1'b1)); // R5
   AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !clr_i) |=> $stable(cyc_o)); // R5

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
   import pcb_pkg::*;
#(
   parameter int NUM_CTR = 16,
   parameter int CTR_W   = 32,
   parameter int NUM_EVT = 64,
   parameter int CYC_W   = 56,
   parameter int ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_EVT-1:0] events_in,
   output logic [NUM_CTR-1:0] ovf_pulse
);

   localparam int NUM_SEL_REG = NUM_CTR / 4;

   if (NUM_CTR % 4 != 0 || NUM_CTR < 4 || NUM_CTR > 64) begin : g_bad_ctr
      $error("NUM_CTR must be a multiple of 4 in 4..64");
   end
   if (NUM_EVT < 1 || NUM_EVT > 64) begin : g_bad_evt
      $error("NUM_EVT must be in 1..64");
   end
   if (CTR_W < 1 || CTR_W > 32) begin : g_bad_ctr_w
      $error("CTR_W must be in 1..32");
   end
   if (CYC_W < 1 || CYC_W > 64) begin : g_bad_cyc_w
      $error("CYC_W must be in 1..64");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must be at least 12");
   end

   logic               run, clr;
   evsel_t             sel [NUM_CTR];
   logic [7:0]         tsel;
   logic [NUM_CTR-1:0] load;
   logic [CTR_W-1:0]   cnt [NUM_CTR];
   logic [CYC_W-1:0]   cyc;
   logic [63:0]        cyc_pad;

   pcb_ctrl #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (bus_addr),
      .we_i    (bus_we),
      .wdata_i (bus_wdata),
      .run_o   (run),
      .clr_o   (clr),
      .sel_o   (sel),
      .tsel_o  (tsel),
      .load_o  (load)
   );

   for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
      pcb_counter #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT)) ctr_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .run_i      (run),
         .clr_i      (clr),
         .sel_i      (sel[c]),
         .events_i   (events_in),
         .load_i     (load[c]),
         .load_val_i (bus_wdata[CTR_W-1:0]),
         .cnt_o      (cnt[c]),
         .ovf_o      (ovf_pulse[c])
      );
   end

   pcb_cycle #(.CYC_W(CYC_W)) cyc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (run),
      .clr_i (clr),
      .cyc_o (cyc)
   );

   assign cyc_pad = 64'(cyc);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CTRL))
         bus_rdata = {31'b0, run};
      if (bus_addr == ADDR_W'(OFS_TSEL))
         bus_rdata = {24'b0, tsel};
      if (bus_addr == ADDR_W'(OFS_CYC_HI))
         bus_rdata = cyc_pad[63:32];
      if (bus_addr == ADDR_W'(OFS_CYC_LO))
         bus_rdata = cyc_pad[31:0];
      for (int s = 0; s < NUM_SEL_REG; s++) begin
         if (bus_addr == ADDR_W'(OFS_SEL_BASE + 4 * s))
            bus_rdata = {sel_to_byte(sel[4*s+3]), sel_to_byte(sel[4*s+2]),
                         sel_to_byte(sel[4*s+1]), sel_to_byte(sel[4*s])};
      end
      for (int c = 0; c < NUM_CTR; c++) begin
         if (bus_addr == ADDR_W'(OFS_CNT_BASE + 4 * c))
            bus_rdata = 32'(cnt[c]);
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (ovf_pulse == '0)); // R1
   AST_PRELOAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_PRELOAD)) |-> (bus_rdata == '0)); // R6

endmodule

// File: tb/perf_ctr_bank_tb.sv
module perf_ctr_bank_tb_top;

   localparam time CLK_P = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] events_in = '0;
   logic [15:0] ovf_pulse;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   bit rd_vld = 1'b0;

   typedef struct {
      logic [31:0] exp;
      logic [11:0] addr;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #(CLK_P/2) clk = ~clk;

   perf_ctr_bank dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .events_in (events_in),
      .ovf_pulse (ovf_pulse)
   );

   task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
      item_t it;
      it.exp  = exp;
      it.addr = a;
      it.tag  = tag;
      bus_addr = a;
      bus_we   = 1'b0;
      sb_q.push_back(it);
      rd_vld = 1'b1;
      @(negedge clk);
      rd_vld = 1'b0;
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         if (rd_vld && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            chk(bus_rdata, it.exp, $sformatf("%s @0x%03h", it.tag, it.addr));
         end
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin : watchdog
      #(CLK_P * 50000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(32'(ovf_pulse), 32'h0, "R1 ovf after reset");
      rd(12'hC00, 32'h0, "R1 ctrl");
      rd(12'hC78, 32'h0, "R1 counter0");
      rd(12'hCB4, 32'h0, "R1 counter15");
      rd(12'hC14, 32'h0, "R1 cycle low");
      rd(12'hC10, 32'h0, "R1 cycle high");
      rd(12'hC68, 32'h0, "R1 selector");
      rd(12'hC08, 32'h0, "R1 test-select");

      // R3 selector packing, bit 6 dropped
      wr(12'hC68, 32'hFFC58183);
      wr(12'hC74, 32'h00008A0A);
      rd(12'hC68, 32'hBF858183, "R3 selector group 0");
      rd(12'hC74, 32'h00008A0A, "R3 selector group 3");
      rd(12'hC6C, 32'h0, "R3 untouched group");

      // R4/R5 run of 10 cycles with constant events
      events_in[3]  = 1'b1;
      events_in[63] = 1'b1;
      events_in[10] = 1'b1;
      wr(12'hC00, 32'h1);
      rd(12'hC00, 32'h1, "R2 run flag set");
      repeat (8) @(negedge clk);
      wr(12'hC00, 32'h2);
      rd(12'hC00, 32'h0, "R2 run flag cleared");
      rd(12'hC78, 32'd10, "R4 counter0 ev3");
      rd(12'hC7C, 32'd0,  "R4 counter1 quiet event");
      rd(12'hC84, 32'd10, "R4 counter3 ev63");
      rd(12'hCA8, 32'd0,  "R4 counter12 disabled");
      rd(12'hCAC, 32'd10, "R4 counter13 ev10");
      rd(12'hC14, 32'd10, "R5 cycle low");
      rd(12'hC10, 32'd0,  "R5 cycle high");

      // R4 second run of 7 cycles, different events
      events_in[3] = 1'b0;
      events_in[5] = 1'b1;
      wr(12'hC00, 32'h1);
      repeat (6) @(negedge clk);
      wr(12'hC00, 32'h2);
      rd(12'hC78, 32'd10, "R4 counter0 held");
      rd(12'hC80, 32'd7,  "R4 counter2 ev5");
      rd(12'hC84, 32'd17, "R4 counter3 accumulates");
      rd(12'hC14, 32'd17, "R5 cycle accumulates");

      // R2 wipe beats go, selectors kept
      wr(12'hC00, 32'h5);
      rd(12'hC00, 32'h0,  "R2 wipe+go leaves stopped");
      rd(12'hC84, 32'h0,  "R2 counter3 wiped");
      rd(12'hC14, 32'h0,  "R2 cycle wiped");
      repeat (3) @(negedge clk);
      rd(12'hCAC, 32'h0,  "R2 counter13 idle after wipe");
      rd(12'hC68, 32'hBF858183, "R2 selectors kept");
      wr(12'hC00, 32'h3);
      repeat (2) @(negedge clk);
      rd(12'hCAC, 32'h0,  "R2 halt beats go");

      // R6 preload path
      wr(12'hC08, 32'd21);
      rd(12'hC08, 32'd21, "R6 test-select readback");
      wr(12'hC0C, 32'hFFFFFFFD);
      wr(12'hC08, 32'd0);
      rd(12'hC80, 32'hFFFFFFFD, "R6 counter2 loaded");
      rd(12'hC84, 32'h0, "R6 counter3 not loaded");
      rd(12'hC0C, 32'h0, "R6 preload reads zero");
      wr(12'hC08, 32'd34);
      wr(12'hC0C, 32'h12345678);
      wr(12'hC08, 32'd0);
      rd(12'hCB4, 32'h12345678, "R6 counter15 loaded");

      // R7 out-of-range codes
      wr(12'hC08, 32'd18);
      wr(12'hC0C, 32'h0000AAAA);
      wr(12'hC08, 32'd35);
      wr(12'hC0C, 32'h0000BBBB);
      wr(12'hC08, 32'd0);
      wr(12'hC0C, 32'h0000CCCC);
      rd(12'hC78, 32'h0, "R7 counter0 unchanged");
      rd(12'hC80, 32'hFFFFFFFD, "R7 counter2 unchanged");
      rd(12'hCA8, 32'h0, "R7 counter12 unchanged");
      rd(12'hCB4, 32'h12345678, "R7 counter15 unchanged");

      // R8 wrap and pulse
      events_in[63] = 1'b0;
      wr(12'hC00, 32'h1);
      @(negedge clk);
      chk(32'(ovf_pulse), 32'h0, "R8 no pulse before wrap");
      @(negedge clk);
      @(negedge clk);
      chk(32'(ovf_pulse), 32'h4, "R8 pulse after wrap");
      @(negedge clk);
      chk(32'(ovf_pulse), 32'h0, "R8 pulse one cycle");
      wr(12'hC00, 32'h2);
      rd(12'hC80, 32'd2, "R8 counter2 after wrap");

      // R6 load wins over counting during a run
      wr(12'hC00, 32'h1);
      wr(12'hC08, 32'd21);
      wr(12'hC0C, 32'd100);
      wr(12'hC08, 32'd0);
      wr(12'hC00, 32'h2);
      rd(12'hC80, 32'd102, "R6 load beats increment");

      // R9 unmapped space
      wr(12'hC04, 32'hFFFFFFFF);
      rd(12'hC04, 32'h0, "R9 hole reads zero");
      rd(12'hC00, 32'h0, "R9 hole write left ctrl");
      wr(12'hC78, 32'h00000055);
      rd(12'hC78, 32'h0, "R9 counter write ignored");
      wr(12'hCB8, 32'h0000FFFF);
      rd(12'hCB8, 32'h0, "R9 past counters");
      rd(12'hD00, 32'h0, "R9 far offset");
      rd(12'hC69, 32'h0, "R9 misaligned");
      rd(12'hC64, 32'h0, "R9 below selectors");

      repeat (3) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule